// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block holds the interrupt state of a serial bus controller. The transfer engine sends single-cycle event pulses, one wire per source. Each pulse sets a sticky bit in a status register, and that bit stays set until software writes a one to it. A mask register decides which pending bits can reach the interrupt line. Software cannot write the mask directly. It writes ones to a separate unmask address or to a separate mask-set address, and both of those addresses are write-only. All four registers use the same bit positions.

The bit positions are:

- bit 0: transfer complete
- bit 1: data threshold
- bit 2: NACK
- bit 3: timeout
- bit 4: slave ready
- bit 5: receive overflow
- bit 6: transmit overflow
- bit 7: receive underflow
- bit 8: reserved
- bit 9: arbitration lost

The NACK, arbitration-lost and the three FIFO overflow and underflow bits are the error group. The interrupt output is a registered level. It is high while at least one status bit is set and unmasked.

The register port is a simple word-indexed interface. A write strobe carries an address and write data. Read data is a combinational function of the address, and reads have no side effects.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset, status reads 0, the mask reads 0x2FF (every implemented source masked, reserved bit 8 reads 0) and irq_o is low.
- R2: An event pulse on an implemented bit sets that status bit at the next clock edge, whatever the mask. The bit stays set with no further pulses.
- R3: A write to address 0 (status) clears each status bit whose write-data bit is 1. Bits written with 0 are unchanged.
- R4: When an event pulse and a clear write hit the same status bit in the same cycle, the bit ends set.
- R5: A write to address 2 (unmask) clears the mask bits written with 1. Bits written with 0 are unchanged.
- R6: A write to address 3 (mask-set) sets the mask bits written with 1. Bits written with 0 are unchanged.
- R7: The mask at address 1 is read-only. A write to address 1 changes neither the mask nor the status.
- R8: Reads of address 2 and address 3 return 0.
- R9: irq_o is high in the cycle after one in which some status bit is set with its mask bit 0, and low otherwise.
- R10: Reserved bit 8 and all bits above bit 9 read 0 in status and mask. Event pulses and writes on bit 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Single-cycle event pulses, one per source bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 status, 1 mask, 2 unmask, 3 mask-set |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Registered interrupt level |

## Verification
A directed sequence tries the block with several input patterns, and each one separates a different fault:

- A pulse while the source is masked shows that the status bit is sticky and that the mask only gates the interrupt line.
- Zero-valued writes to the status, unmask and mask-set addresses separate a write-one behaviour from a plain overwrite.
- A write to the mask address shows that the mask cannot be loaded directly.
- A pulse and a clear on the same bit in the same cycle exposes the wrong priority.
- Pulses and writes on the reserved bit expose a bit that was wrongly implemented.

A long run of mixed pulses and writes to random addresses is then compared against the behavioural model on every cycle, for both the read data and the interrupt level.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;

  typedef enum logic [1:0] {
    REG_STAT    = 2'd0,
    REG_MASK    = 2'd1,
    REG_UNMASK  = 2'd2,
    REG_MASKSET = 2'd3
  } reg_sel_e;

  // Next status value: clears first, then new events win.
  function automatic logic [31:0] status_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] evt);
    return (cur & ~clr) | evt;
  endfunction

  // Next mask value: set requests and unmask requests never coincide.
  function automatic logic [31:0] mask_next(input logic [31:0] cur,
                                            input logic [31:0] unmask,
                                            input logic [31:0] setm);
    return (cur & ~unmask) | setm;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int          SRC_W = 10,
  parameter logic [31:0] IMPL  = 32'h2FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] status_o
);
  import irq_setclr_pkg::*;

  logic unused_rsv;
  assign unused_rsv = ^((evt_i | clr_i) & ~IMPL[SRC_W-1:0]);

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic st_q;
      logic st_d;
      always_comb begin
        logic [31:0] nxt;
        nxt  = status_next({31'd0, st_q}, {31'd0, clr_i[i]}, {31'd0, evt_i[i]});
        st_d = nxt[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= st_d;
      end
      assign status_o[i] = st_q;

      assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[i] |=> status_o[i]);
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !evt_i[i]) |=> !status_o[i]);
      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !evt_i[i]) |=> $stable(status_o[i]));
      assert_collide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && evt_i[i]) |=> status_o[i]);
    end else begin : g_rsv
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int          SRC_W = 10,
  parameter logic [31:0] IMPL  = 32'h2FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] unmask_i,
  input  logic [SRC_W-1:0] maskset_i,
  output logic [SRC_W-1:0] mask_o
);
  import irq_setclr_pkg::*;

  logic unused_rsv;
  assign unused_rsv = ^((unmask_i | maskset_i) & ~IMPL[SRC_W-1:0]);

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic mk_q;
      logic mk_d;
      always_comb begin
        logic [31:0] nxt;
        nxt  = mask_next({31'd0, mk_q}, {31'd0, unmask_i[i]}, {31'd0, maskset_i[i]});
        mk_d = nxt[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= 1'b1;
        else        mk_q <= mk_d;
      end
      assign mask_o[i] = mk_q;

      assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_i[i] |=> !mask_o[i]);
      assert_maskset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        maskset_i[i] |=> mask_o[i]);
      assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_i[i] && !maskset_i[i]) |=> $stable(mask_o[i]));
    end else begin : g_rsv
      assign mask_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 10
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SRC_W-1:0]  status_i,
  input  logic [SRC_W-1:0]  mask_i,
  output logic [SRC_W-1:0]  clr_o,
  output logic [SRC_W-1:0]  unmask_o,
  output logic [SRC_W-1:0]  maskset_o,
  output logic [DATA_W-1:0] rdata_o
);
  import irq_setclr_pkg::*;

  localparam int PAD_W = DATA_W - SRC_W;

  logic hit_stat, hit_mask, hit_unmask, hit_maskset;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:SRC_W];
  assign hit_stat    = (addr_i == ADDR_W'(REG_STAT));
  assign hit_mask    = (addr_i == ADDR_W'(REG_MASK));
  assign hit_unmask  = (addr_i == ADDR_W'(REG_UNMASK));
  assign hit_maskset = (addr_i == ADDR_W'(REG_MASKSET));

  assign clr_o     = (wr_en_i && hit_stat)    ? wdata_i[SRC_W-1:0] : '0;
  assign unmask_o  = (wr_en_i && hit_unmask)  ? wdata_i[SRC_W-1:0] : '0;
  assign maskset_o = (wr_en_i && hit_maskset) ? wdata_i[SRC_W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_stat)      rdata_o = {{PAD_W{1'b0}}, status_i};
    else if (hit_mask) rdata_o = {{PAD_W{1'b0}}, mask_i};
  end
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl #(
  parameter int          ADDR_W = 2,
  parameter int          DATA_W = 32,
  parameter int          SRC_W  = 10,
  parameter logic [31:0] RSV    = 32'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [31:0] IMPL = ~RSV & ((32'd1 << SRC_W) - 32'd1);

  logic [SRC_W-1:0] status_w, mask_w;
  logic [SRC_W-1:0] clr_w, unmask_w, maskset_w;
  logic [SRC_W-1:0] pend_w;
  logic             pend_any;
  logic             irq_q;

  irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_regif (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status_w),
    .mask_i   (mask_w),
    .clr_o    (clr_w),
    .unmask_o (unmask_w),
    .maskset_o(maskset_w),
    .rdata_o  (rdata_o)
  );

  irq_status_bank #(.SRC_W(SRC_W), .IMPL(IMPL)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .clr_i   (clr_w),
    .status_o(status_w)
  );

  irq_mask_bank #(.SRC_W(SRC_W), .IMPL(IMPL)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .unmask_i (unmask_w),
    .maskset_i(maskset_w),
    .mask_o   (mask_w)
  );

  assign pend_w   = status_w & ~mask_w;
  assign pend_any = |pend_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end
  assign irq_o = irq_q;

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pend_any));
  assert_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> !$past(pend_any));
  assert_mask_wr_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(1) && evt_i == '0) |=>
      ($stable(mask_w) && $stable(status_w)));
endmodule

// File: tb/irq_setclr_ctrl_tb_top.sv
module irq_setclr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model state
  int m_stat = 0;
  int m_mask = 'h2FF;
  bit m_irq = 0;
  localparam int VALID = 'h2FF;

  irq_setclr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle reference model and comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = VALID; m_irq = 0;
    end else begin
      bit nirq;
      int wd;
      nirq = ((m_stat & ~m_mask) & VALID) != 0;
      wd = int'(wdata) & VALID;
      if (we && addr == 2'd0) m_stat = m_stat & ~wd;
      m_stat = (m_stat | int'(evt)) & VALID;
      if (we && addr == 2'd2) m_mask = m_mask & ~wd;
      if (we && addr == 2'd3) m_mask = (m_mask | wd) & VALID;
      m_irq = nirq;
    end
    #2;
    if (!done) begin
      check("R9 irq", int'(irq), int'(m_irq));
      case (addr)
        2'd0: check("R2 status", int'(rdata), m_stat);
        2'd1: check("R5 mask", int'(rdata), m_mask);
        default: check("R8 wo-read", int'(rdata), 0);
      endcase
    end
  end

  task automatic drive(input logic [9:0] e, input logic w, input logic [1:0] a,
                       input logic [31:0] d);
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = d;
    @(negedge clk);
    evt = '0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, int'(rdata), exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    rd(2'd0, 0, "R1 status");
    rd(2'd1, 'h2FF, "R1 mask");
    // masked event still latches
    drive(10'h005, 1'b0, 2'd0, 0);
    rd(2'd0, 'h005, "R2 sticky");
    repeat (2) @(negedge clk);
    check("R9 masked-low", int'(irq), 0);
    // unmask bit 0
    drive(10'h000, 1'b1, 2'd2, 32'h1);
    rd(2'd1, 'h2FE, "R5 unmask");
    repeat (2) @(negedge clk);
    check("R9 raised", int'(irq), 1);
    drive(10'h000, 1'b1, 2'd2, 32'h0);
    rd(2'd1, 'h2FE, "R5 zero-write");
    // direct mask write ignored
    drive(10'h000, 1'b1, 2'd1, 32'h0);
    rd(2'd1, 'h2FE, "R7 mask-ro");
    rd(2'd0, 'h005, "R7 status-kept");
    rd(2'd2, 0, "R8 unmask-read");
    rd(2'd3, 0, "R8 maskset-read");
    // clear bit 0
    drive(10'h000, 1'b1, 2'd0, 32'h1);
    rd(2'd0, 'h004, "R3 w1c");
    repeat (2) @(negedge clk);
    check("R9 dropped", int'(irq), 0);
    drive(10'h000, 1'b1, 2'd0, 32'h0);
    rd(2'd0, 'h004, "R3 zero-write");
    // reserved bit
    drive(10'h100, 1'b0, 2'd0, 0);
    rd(2'd0, 'h004, "R10 rsv-evt");
    drive(10'h000, 1'b1, 2'd3, 32'hFFFF_FFFF);
    rd(2'd1, 'h2FF, "R10 rsv-mask");
    drive(10'h000, 1'b1, 2'd2, 32'h0000_0104);
    rd(2'd1, 'h2FB, "R10 rsv-unmask");
    repeat (2) @(negedge clk);
    check("R9 bit2", int'(irq), 1);
    // collision: event and clear on bit 2
    drive(10'h004, 1'b1, 2'd0, 32'h4);
    rd(2'd0, 'h004, "R4 collide");
    // mask-set drops the line
    drive(10'h000, 1'b1, 2'd3, 32'h4);
    rd(2'd1, 'h2FF, "R6 maskset");
    repeat (2) @(negedge clk);
    check("R6 irq-off", int'(irq), 0);
    drive(10'h000, 1'b1, 2'd3, 32'h0);
    rd(2'd1, 'h2FF, "R6 zero-write");
    // mixed traffic compared every cycle against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(((i % 3) == 0) ? 10'(r >> 7) : 10'h0, r[0], r[2:1], $urandom);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule